// File: doc/BRIEF.md
# Tiled 53x53 Unsigned Significand Multiplier

This block multiplies two 53-bit unsigned significands and returns the full 106-bit product. It sits in the datapath of a double-width floating-point multiplier, which handles sign, exponent, normalisation and rounding around it. Each operand field is cut into nine rectangular tiles, so that every partial product fits a narrow hardware multiplier of at most 24 by 17 bits.

Eight of the tiles form two chains of four. Inside a chain, consecutive tiles differ in weight by exactly 2^17, and each chain is summed one tile per pipeline stage. A closing stage adds the first chain sum, the second chain sum raised by 2^24, and a ten-by-ten centre tile raised by 2^48. The pipeline accepts a new operand pair on every clock. Each result emerges a fixed number of cycles later, marked by a valid strobe. Between results the output register keeps its value.

Top module: `sigmul_tiled`

## Requirements
- R1: While reset is asserted, `out_valid` is 0 and `product` is all zeros.
- R2: Every result flagged by `out_valid` equals the exact unsigned product of the two 53-bit operands captured with it, as a 106-bit value with no truncation.
- R3: An operand pair sampled at a rising edge with `in_valid` high produces `out_valid` high after the fifth rising edge counted from that sample edge (that edge included). `out_valid` is high in a cycle exactly when `in_valid` was high five edges earlier.
- R4: Operand pairs presented on consecutive cycles are all accepted, and their results come out on consecutive cycles in the same order.
- R5: When `out_valid` is low, `product` keeps the last result. Operands presented with `in_valid` low change neither `product` nor `out_valid`.
- R6: All-ones operands give (2^53-1)^2, and a zero in either operand gives zero.
- R7: For single-bit operands 2^i and 2^j, the product is exactly 2^(i+j) for every i and j. This includes the bit positions 16, 17, 23, 24, 33, 34, 40 and 41 where the tiles meet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies the operand pair on this edge |
| op_a | input | 53 | Unsigned operand A (hidden bit at the top) |
| op_b | input | 53 | Unsigned operand B (hidden bit at the top) |
| out_valid | output | 1 | Product register holds a new result this cycle |
| product | output | 106 | Unsigned product A times B |

## Verification
A tile with wrong bounds, a wrong chain offset, or a centre tile delayed by the wrong number of stages makes the product wrong in the very cycle `out_valid` rises. Which operand pairs expose the fault depends on where it sits. Single-bit operands at the tile edges isolate each tile. All-ones operands exercise every carry at once. A broken valid pipeline or hold enable shows at once as a strobe in the wrong cycle, or as the product moving while the strobe is low. The reference model is compared on every cycle, so such faults are flagged within one cycle of their first effect.

// File: rtl/sigmul_pkg.sv
package sigmul_pkg;
    localparam int OP_W       = 53;
    localparam int PROD_W     = 2 * OP_W;
    localparam int NTILE      = 9;
    localparam int CHAIN_LEN  = 4;
    localparam int CHAIN_STEP = 17;
    localparam int Y_SHIFT    = 24;
    localparam int C_SHIFT    = 48;
    localparam int CENTRE     = NTILE - 1;
    // tile cycle: tiles registered, one stage per chain step after the first, final sum
    localparam int LAT        = CHAIN_LEN + 1;

    // tile order: chain X (0..3), chain Y (4..7), centre (8)
    localparam int TA_LO [NTILE] = '{ 0,  0,  0, 17, 24, 41, 34, 34, 24};
    localparam int TA_HI [NTILE] = '{23, 23, 16, 33, 40, 52, 52, 52, 33};
    localparam int TB_LO [NTILE] = '{ 0, 17, 34, 34,  0,  0, 24, 41, 24};
    localparam int TB_HI [NTILE] = '{16, 33, 52, 52, 23, 23, 40, 52, 33};

    function automatic int tile_width(input int t);
        return (TA_HI[t] - TA_LO[t] + 1) + (TB_HI[t] - TB_LO[t] + 1);
    endfunction

    function automatic int widest_tile();
        int w = 0;
        for (int t = 0; t < NTILE; t++) begin
            if (tile_width(t) > w) w = tile_width(t);
        end
        return w;
    endfunction

    localparam int TILE_W   = widest_tile();
    localparam int CENTRE_W = tile_width(CENTRE);
endpackage

// File: rtl/sigmul_tiles.sv
module sigmul_tiles
    import sigmul_pkg::*;
(
    input  logic [OP_W-1:0]                 op_a,
    input  logic [OP_W-1:0]                 op_b,
    output logic [NTILE-1:0][TILE_W-1:0]    tiles
);
    for (genvar g = 0; g < NTILE; g++) begin : g_tile
        localparam int AW = TA_HI[g] - TA_LO[g] + 1;
        localparam int BW = TB_HI[g] - TB_LO[g] + 1;
        logic [AW-1:0]    slice_a;
        logic [BW-1:0]    slice_b;
        logic [AW+BW-1:0] part;
        assign slice_a  = op_a[TA_HI[g]:TA_LO[g]];
        assign slice_b  = op_b[TB_HI[g]:TB_LO[g]];
        assign part     = slice_a * slice_b;
        assign tiles[g] = TILE_W'(part);
    end
endmodule

// File: rtl/sigmul_chain.sv
module sigmul_chain #(
    parameter int TW   = 41,
    parameter int SW   = 106,
    parameter int STEP = 17,
    parameter int LEN  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LEN-1:0][TW-1:0]   tiles,
    output logic [SW-1:0]            sum
);
    typedef struct packed {
        logic [LEN-1:1][SW-1:0]           acc;
        logic [LEN-2:1][LEN-1:0][TW-1:0]  tl;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.acc[1] = SW'(tiles[0]) + (SW'(tiles[1]) << STEP);
        st_d.tl[1]  = tiles;
        for (int k = 2; k < LEN; k++) begin
            st_d.acc[k] = st_q.acc[k-1] + (SW'(st_q.tl[k-1][k]) << (STEP * k));
            if (k < LEN - 1) st_d.tl[k] = st_q.tl[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum = st_q.acc[LEN-1];
endmodule

// File: rtl/sigmul_tiled.sv
module sigmul_tiled
    import sigmul_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [OP_W-1:0]      op_a,
    input  logic [OP_W-1:0]      op_b,
    output logic                 out_valid,
    output logic [PROD_W-1:0]    product
);
    typedef struct packed {
        logic [NTILE-1:0][TILE_W-1:0]      tl;
        logic [CHAIN_LEN-2:0][TILE_W-1:0]  cd;
        logic [LAT-1:0]                    vld;
        logic [PROD_W-1:0]                 prod;
    } pipe_t;

    pipe_t pp_d, pp_q;

    logic [NTILE-1:0][TILE_W-1:0] tiles_raw;
    logic [PROD_W-1:0]            sum_x, sum_y, centre_w;

    sigmul_tiles u_tiles (
        .op_a  (op_a),
        .op_b  (op_b),
        .tiles (tiles_raw)
    );

    sigmul_chain #(.TW(TILE_W), .SW(PROD_W), .STEP(CHAIN_STEP), .LEN(CHAIN_LEN)) u_chain_x (
        .clk   (clk),
        .rst_n (rst_n),
        .tiles (pp_q.tl[CHAIN_LEN-1:0]),
        .sum   (sum_x)
    );

    sigmul_chain #(.TW(TILE_W), .SW(PROD_W), .STEP(CHAIN_STEP), .LEN(CHAIN_LEN)) u_chain_y (
        .clk   (clk),
        .rst_n (rst_n),
        .tiles (pp_q.tl[2*CHAIN_LEN-1:CHAIN_LEN]),
        .sum   (sum_y)
    );

    assign centre_w = PROD_W'(pp_q.cd[CHAIN_LEN-2][CENTRE_W-1:0]);

    always_comb begin
        pp_d       = pp_q;
        pp_d.tl    = tiles_raw;
        pp_d.cd[0] = pp_q.tl[CENTRE];
        for (int k = 1; k < CHAIN_LEN - 1; k++) pp_d.cd[k] = pp_q.cd[k-1];
        pp_d.vld   = {pp_q.vld[LAT-2:0], in_valid};
        if (pp_q.vld[LAT-2]) begin
            pp_d.prod = sum_x + (sum_y << Y_SHIFT) + (centre_w << C_SHIFT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pp_q <= '0;
        else        pp_q <= pp_d;
    end

    assign out_valid = pp_q.vld[LAT-1];
    assign product   = pp_q.prod;
endmodule

// File: rtl/sigmul_chk.sv
module sigmul_chk
    import sigmul_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [OP_W-1:0]      op_a,
    input logic [OP_W-1:0]      op_b,
    input logic                 out_valid,
    input logic [PROD_W-1:0]    product
);
    logic [3:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != '1) since_rst <= since_rst + 4'd1;
    end

    // R1
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && product == '0));

    // R3
    assert_valid_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

    // R2
    assert_exact_product_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'(LAT) && out_valid) |->
        (product == PROD_W'($past(op_a, LAT)) * PROD_W'($past(op_b, LAT))));

    // R5
    assert_hold_product_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'd1 && !out_valid) |-> $stable(product));
endmodule

bind sigmul_tiled sigmul_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/sim_sigmul_tiled.sv
`timescale 1ns/1ps
module sim_sigmul_tiled;
    localparam int  W    = 53;
    localparam int  PW   = 106;
    localparam int  DLY  = 5;
    localparam time HALF = 10ns;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [W-1:0]  op_a, op_b;
    logic          out_valid;
    logic [PW-1:0] product;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    bit    cmp_on = 0;
    string tag    = "R1";

    // behavioural expectation: a queue of DLY entries plus a held output value
    logic          ev_q [DLY];
    logic [PW-1:0] ep_q [DLY];
    logic [PW-1:0] held;

    sigmul_tiled u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .out_valid (out_valid),
        .product   (product)
    );

    always #HALF clk = ~clk;

    function automatic logic [PW-1:0] mul_ref(input logic [W-1:0] a, input logic [W-1:0] b);
        return PW'(a) * PW'(b);
    endfunction

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DLY; k++) begin
                ev_q[k] <= 1'b0;
                ep_q[k] <= '0;
            end
            held <= '0;
        end else begin
            ev_q[0] <= in_valid;
            ep_q[0] <= mul_ref(op_a, op_b);
            for (int k = 1; k < DLY; k++) begin
                ev_q[k] <= ev_q[k-1];
                ep_q[k] <= ep_q[k-1];
            end
            if (ev_q[DLY-2]) held <= ep_q[DLY-2];
        end
    end

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check(tag, PW'(out_valid), PW'(ev_q[DLY-1]), "out_valid");
            check(tag, product, held, "product");
        end
    end

    task automatic issue(input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
        in_valid = v;
        op_a     = a;
        op_b     = b;
        @(negedge clk);
    endtask

    function automatic logic [W-1:0] rnd53();
        return W'({$urandom, $urandom});
    endfunction

    initial begin
        #(HALF * 2 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        logic [PW-1:0] last;
        int pos [11] = '{0, 16, 17, 23, 24, 33, 34, 40, 41, 51, 52};

        rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", PW'(out_valid), '0, "out_valid in reset");
        check("R1", product, '0, "product in reset");
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1;

        // R3: single operation latency
        tag = "R3";
        issue(1'b1, 53'd12345, 53'd678);
        in_valid = 1'b0;
        n = 1;
        while (!out_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        check("R3", PW'(n), PW'(DLY), "latency in edges");
        check("R3", product, mul_ref(53'd12345, 53'd678), "latency result");
        repeat (4) @(negedge clk);

        // R6: extremes
        tag = "R6";
        issue(1'b1, '1, '1);
        issue(1'b1, '0, rnd53());
        issue(1'b1, rnd53(), '0);
        issue(1'b1, '1, 53'd1);
        in_valid = 1'b0;
        repeat (DLY + 1) @(negedge clk);
        check("R6", product, mul_ref('1, 53'd1), "all-ones times one");

        // R7: single bits across tile seams
        tag = "R7";
        foreach (pos[i]) begin
            foreach (pos[j]) issue(1'b1, W'(1) << pos[i], W'(1) << pos[j]);
        end
        in_valid = 1'b0;
        repeat (DLY + 1) @(negedge clk);
        check("R7", product, PW'(1) << 104, "top bit pair");

        // R4: back-to-back random stream
        tag = "R4";
        for (int k = 0; k < 300; k++) issue(1'b1, rnd53(), rnd53());

        // R2: random operands with random gaps
        tag = "R2";
        for (int k = 0; k < 400; k++) issue(1'($urandom_range(0, 2) != 0), rnd53(), rnd53());
        in_valid = 1'b0;
        repeat (DLY + 2) @(negedge clk);

        // R5: operands without valid leave the output alone
        tag = "R5";
        last = product;
        for (int k = 0; k < 20; k++) begin
            issue(1'b0, rnd53(), rnd53());
            check("R5", product, last, "held product");
            check("R5", PW'(out_valid), '0, "out_valid idle");
        end

        cmp_on = 0;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule